// File: doc/BRIEF.md
# Configurable Serial Receive Front End

This block is the capture stage in front of a bit-oriented link controller. A fast system clock samples a slow serial clock and a serial data line, both of which come from outside the system clock domain. Static control inputs choose which of two data pins feeds the receiver and which of two clock pins paces it. A further control input chooses whether bits are taken on the rising or the falling edge of that clock. Each accepted bit is shifted into a byte, least significant bit first. Every complete byte goes into a four-entry receive FIFO, and a processor drains the FIFO through a read strobe. The data word at the head of the FIFO is always visible on the read data output.

The receiver can be switched off. While it is off, no bits are accepted, and both the partial byte and the queued bytes are left untouched. Before the receiver is switched back on after a disable, software must pulse the receiver reset. Software must also pulse it after changing the edge choice. If the receiver is enabled again without that pulse, a sticky error flag is raised. The receiver reset clears the partial byte and the overrun flag. It does not touch the FIFO. The first programmed clock edge that follows the reset latches bit 0, so a gated or burst clock is handled without any alignment edge.

Top module: `serial_rx_front`

## Requirements
- R1: While `rx_en` is 0, edges on the selected clock capture nothing: no byte enters the FIFO and the partial-byte position does not advance.
- R2: Dropping `rx_en` does not reset the receiver. Queued bytes stay readable, and bits captured before the disable are completed by bits captured after the enable.
- R3: If `rx_en` rises after a disable and `rx_reset` has not been pulsed since that disable, `reenable_err` becomes 1 and stays 1 until `rst_n`. A disable, then a reset pulse, then an enable leaves it at 0.
- R4: `data_sel` = 0 takes serial data from `ser_data_a`; `data_sel` = 1 takes it from `ser_data_b`. The other data pin has no effect.
- R5: `clk_sel` = 0 uses `ser_clk_rx` as the bit clock; `clk_sel` = 1 uses `ser_clk_tx`. Edges on the other clock pin have no effect.
- R6: `edge_rise` = 1 latches data on a 0-to-1 transition of the selected clock. `edge_rise` = 0 latches it on a 1-to-0 transition. Transitions of the opposite polarity capture nothing.
- R7: After a `rx_reset` pulse, the first programmed edge of the selected clock latches bit 0 of the next byte.
- R8: Bits are assembled least significant bit first: the first captured bit is `rd_data[0]` and the eighth is `rd_data[7]`. Each eighth bit completes a byte.
- R9: The FIFO holds 4 bytes in arrival order. `rd_data` shows the oldest byte, and `rd_en` removes it. `fifo_empty` is 1 and `fifo_full` is 0 after `rst_n`.
- R10: A byte that completes while the FIFO is full and `rd_en` is 0 is dropped, and `overrun` is set. A byte that completes in the same cycle as a read of a full FIFO is stored, and `overrun` stays 0.
- R11: `rx_reset` clears the partial byte and `overrun`, and leaves the FIFO contents and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| rx_reset | input | 1 | One-cycle receiver reset pulse |
| data_sel | input | 1 | 0: data pin A, 1: data pin B |
| clk_sel | input | 1 | 0: receive clock pin, 1: transmit clock pin |
| edge_rise | input | 1 | 1: rising edge latches, 0: falling edge latches |
| ser_clk_rx | input | 1 | Dedicated receive clock pin (asynchronous) |
| ser_clk_tx | input | 1 | Transmit clock pin (asynchronous) |
| ser_data_a | input | 1 | Serial data pin A (asynchronous) |
| ser_data_b | input | 1 | Serial data pin B (asynchronous) |
| rd_en | input | 1 | Pop the head of the FIFO |
| rd_data | output | 8 | Byte at the head of the FIFO |
| fifo_empty | output | 1 | FIFO holds no byte |
| fifo_full | output | 1 | FIFO holds 4 bytes |
| overrun | output | 1 | A completed byte was dropped |
| reenable_err | output | 1 | Sticky: enabled again without a receiver reset |

## Verification
Two events can land on the same system clock edge: the eighth bit of a byte being pushed, and the processor popping a full FIFO. The bench fills the FIFO and then sends another byte. It raises `rd_en` for exactly the cycle in which the synchronized programmed edge of the eighth bit arrives, which is two system clocks after the pin changes. The result is judged by three things: `overrun` staying 0, `fifo_full` staying 1, and the popped sequence ending with the new byte. A separate run without the pop must set `overrun` and drop the byte.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef struct packed {
    logic dsel;
    logic csel;
    logic rise;
  } srx_cfg_t;

  // True when the sampled clock moved in the programmed direction.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic rise);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign d_sync = stg[STAGES-1];

endmodule

// File: rtl/srx_edge.sv
module srx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic rise_sel,
  output logic edge_evt
);
  import srx_pkg::*;

  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign edge_evt = edge_hit(cur, prev_q, rise_sel);

  // R6: an event leaves the sampled clock at the programmed level
  p_edge_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> (prev_q == $past(rise_sel)));

endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 bit_stb,
  input  logic                 bit_val,
  output logic                 byte_stb,
  output logic [W-1:0]         byte_out,
  output logic [$clog2(W)-1:0] bit_cnt
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0] shreg_q;

  function automatic logic [W-1:0] put_bit(input logic [W-1:0] v, input logic [CW-1:0] idx,
                                           input logic b);
    logic [W-1:0] r;
    r = v;
    r[idx] = b;
    return r;
  endfunction

  assign byte_out = put_bit(shreg_q, bit_cnt, bit_val);
  assign byte_stb = bit_stb && (bit_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bit_cnt <= '0;
      shreg_q <= '0;
    end else if (bit_stb) begin
      if (bit_cnt == LAST) begin
        bit_cnt <= '0;
        shreg_q <= '0;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg_q <= byte_out;
      end
    end
  end

  // R11: receiver reset returns to bit 0
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bit_cnt == '0));
  // R8: a byte completes only on the last bit position
  p_byte_at_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> (bit_cnt == '0));

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [W-1:0]             wdata,
  input  logic                     rd,
  output logic [W-1:0]             rdata,
  output logic                     empty,
  output logic                     full,
  output logic                     drop,
  output logic [$clog2(DEPTH):0]   count
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, rptr_q;
  logic         do_rd, do_wr;

  assign count = wptr_q - rptr_q;
  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign do_rd = rd && !empty;
  assign do_wr = wr && (!full || do_rd);
  assign drop  = wr && !do_wr;
  assign rdata = mem[rptr_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_wr) wptr_q <= wptr_q + 1'b1;
      if (do_rd) rptr_q <= rptr_q + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk) begin
      if (!rst_n) mem[i] <= '0;
      else if (do_wr && wptr_q[AW-1:0] == AW'(i)) mem[i] <= wdata;
    end
  end

  // R9: occupancy never exceeds the depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R10: a write into a full FIFO without a read leaves it full and unchanged
  p_drop_keeps_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !rd) |=> (full && $stable(wptr_q)));

endmodule

// File: rtl/serial_rx_front.sv
module serial_rx_front #(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_reset,
  input  logic              data_sel,
  input  logic              clk_sel,
  input  logic              edge_rise,
  input  logic              ser_clk_rx,
  input  logic              ser_clk_tx,
  input  logic              ser_data_a,
  input  logic              ser_data_b,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              overrun,
  output logic              reenable_err
);
  import srx_pkg::*;

  localparam int CW = $clog2(DATA_W);
  localparam int AW = $clog2(FIFO_DEPTH);

  srx_cfg_t            cfg;
  logic [1:0]          raw_pair, sync_pair;
  logic                edge_evt, bit_stb, byte_stb, fifo_drop;
  logic [DATA_W-1:0]   byte_out;
  logic [CW-1:0]       bit_cnt;
  logic [AW:0]         fifo_cnt;
  logic                rx_en_q, need_reset_q;

  assign cfg.dsel = data_sel;
  assign cfg.csel = clk_sel;
  assign cfg.rise = edge_rise;

  // bit 1: selected clock, bit 0: selected data
  assign raw_pair = {(cfg.csel ? ser_clk_tx : ser_clk_rx),
                     (cfg.dsel ? ser_data_b : ser_data_a)};

  srx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_pair), .d_sync(sync_pair)
  );

  srx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cur(sync_pair[1]), .rise_sel(cfg.rise), .edge_evt(edge_evt)
  );

  assign bit_stb = edge_evt && rx_en && !rx_reset;

  srx_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(rx_reset), .bit_stb(bit_stb), .bit_val(sync_pair[0]),
    .byte_stb(byte_stb), .byte_out(byte_out), .bit_cnt(bit_cnt)
  );

  srx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(byte_stb), .wdata(byte_out), .rd(rd_en),
    .rdata(rd_data), .empty(fifo_empty), .full(fifo_full), .drop(fifo_drop), .count(fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en_q      <= 1'b0;
      need_reset_q <= 1'b0;
      reenable_err <= 1'b0;
      overrun      <= 1'b0;
    end else begin
      rx_en_q <= rx_en;
      if (rx_reset)               need_reset_q <= 1'b0;
      else if (rx_en_q && !rx_en) need_reset_q <= 1'b1;
      if (rx_en && !rx_en_q && need_reset_q && !rx_reset) reenable_err <= 1'b1;
      if (rx_reset)       overrun <= 1'b0;
      else if (fifo_drop) overrun <= 1'b1;
    end
  end

  // R1: a disabled receiver does not advance its bit position
  p_hold_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_reset) |=> $stable(bit_cnt));
  // R1: a disabled receiver adds nothing to the FIFO
  p_no_fill_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rd_en) |=> $stable(fifo_cnt));
  // R3: error flag is sticky
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reenable_err |=> reenable_err);
  // R10: a dropped byte raises overrun
  p_drop_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_drop && !rx_reset) |=> overrun);
  // R11: receiver reset keeps FIFO occupancy
  p_reset_keeps_fifo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_reset && !rd_en) |=> ($stable(fifo_cnt) && !overrun));

endmodule

// File: tb/serial_rx_front_tb.sv
module serial_rx_front_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, rx_reset = 1'b0;
  logic data_sel = 1'b0, clk_sel = 1'b0, edge_rise = 1'b1;
  logic ser_clk_rx = 1'b0, ser_clk_tx = 1'b0, ser_data_a = 1'b0, ser_data_b = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic fifo_empty, fifo_full, overrun, reenable_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_front dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_reset(rx_reset),
    .data_sel(data_sel), .clk_sel(clk_sel), .edge_rise(edge_rise),
    .ser_clk_rx(ser_clk_rx), .ser_clk_tx(ser_clk_tx),
    .ser_data_a(ser_data_a), .ser_data_b(ser_data_b),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .overrun(overrun), .reenable_err(reenable_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one bit on the selected pins; optionally pop in the cycle the bit is taken
  task automatic send_bit(input logic b, input logic pop);
    if (data_sel) begin ser_data_b = b; ser_data_a = ~b; end
    else          begin ser_data_a = b; ser_data_b = ~b; end
    wait_n(4);
    // pulse on the unselected clock pin: must capture nothing (R5)
    if (clk_sel) ser_clk_rx = ~ser_clk_rx; else ser_clk_tx = ~ser_clk_tx;
    wait_n(4);
    if (clk_sel) ser_clk_rx = ~ser_clk_rx; else ser_clk_tx = ~ser_clk_tx;
    wait_n(4);
    if (clk_sel) ser_clk_tx = edge_rise; else ser_clk_rx = edge_rise;
    @(posedge clk); @(posedge clk); @(negedge clk);
    if (pop) rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    wait_n(3);
    if (clk_sel) ser_clk_tx = ~edge_rise; else ser_clk_rx = ~edge_rise;
    wait_n(4);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic pop_last);
    for (int i = 0; i < 8; i++) send_bit(v[i], pop_last && (i == 7));
  endtask

  task automatic pop_check(input string tag, input logic [7:0] exp);
    chk({tag, " nonempty"}, {31'd0, fifo_empty}, 32'd0);
    chk(tag, {24'd0, rd_data}, {24'd0, exp});
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_reset();
    rx_reset = 1'b1;
    @(negedge clk);
    rx_reset = 1'b0;
  endtask

  task automatic configure(input logic ds, input logic cs, input logic rise);
    rx_en = 1'b0;
    @(negedge clk);
    data_sel = ds; clk_sel = cs; edge_rise = rise;
    ser_clk_rx = ~rise; ser_clk_tx = ~rise;
    wait_n(6);
    pulse_reset();
    rx_en = 1'b1;
    wait_n(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    chk("R9 reset empty", {31'd0, fifo_empty}, 32'd1);
    chk("R9 reset full", {31'd0, fifo_full}, 32'd0);
    chk("R10 reset overrun", {31'd0, overrun}, 32'd0);
    chk("R3 reset err", {31'd0, reenable_err}, 32'd0);

    // R4 R5 R6 R7 R8: every pin/edge combination, each starting right after a reset
    for (int c = 0; c < 8; c++) begin
      logic [7:0] v;
      v = 8'hA5 ^ 8'(c * 37);
      configure(c[0], c[1], c[2]);
      send_byte(v, 1'b0);
      pop_check($sformatf("R4 R5 R6 R7 R8 cfg%0d", c), v);
      chk("R9 empty after pop", {31'd0, fifo_empty}, 32'd1);
    end
    chk("R3 clean path err", {31'd0, reenable_err}, 32'd0);

    // R8: every byte value, LSB first
    configure(1'b0, 1'b0, 1'b1);
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v), 1'b0);
      pop_check("R8 sweep", 8'(v));
    end

    // R11 R7: reset mid-byte realigns to bit 0
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    pulse_reset();
    send_byte(8'h3C, 1'b0);
    pop_check("R11 realign", 8'h3C);
    chk("R11 realign empty", {31'd0, fifo_empty}, 32'd1);

    // R9 R10 R11: fill, overrun, reset keeps FIFO, simultaneous push and pop
    send_byte(8'h11, 1'b0); send_byte(8'h22, 1'b0);
    send_byte(8'h33, 1'b0); send_byte(8'h44, 1'b0);
    chk("R9 full", {31'd0, fifo_full}, 32'd1);
    chk("R10 no overrun yet", {31'd0, overrun}, 32'd0);
    send_byte(8'h55, 1'b0);
    chk("R10 overrun set", {31'd0, overrun}, 32'd1);
    chk("R10 still full", {31'd0, fifo_full}, 32'd1);
    pulse_reset();
    wait_n(1);
    chk("R11 overrun cleared", {31'd0, overrun}, 32'd0);
    chk("R11 fifo kept", {31'd0, fifo_full}, 32'd1);
    chk("R9 head", {24'd0, rd_data}, 32'h11);
    send_byte(8'h66, 1'b1);
    chk("R10 same-cycle overrun", {31'd0, overrun}, 32'd0);
    chk("R10 same-cycle full", {31'd0, fifo_full}, 32'd1);
    pop_check("R10 order 1", 8'h22);
    pop_check("R10 order 2", 8'h33);
    pop_check("R10 order 3", 8'h44);
    pop_check("R10 order 4", 8'h66);
    chk("R9 drained", {31'd0, fifo_empty}, 32'd1);

    // R1 R2 R3: disable mid-byte, bits ignored, re-enable without reset
    for (int i = 0; i < 3; i++) send_bit(1'(8'hD6 >> i), 1'b0);
    rx_en = 1'b0;
    wait_n(2);
    for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0);
    chk("R1 nothing captured", {31'd0, fifo_empty}, 32'd1);
    rx_en = 1'b1;
    wait_n(2);
    chk("R3 err raised", {31'd0, reenable_err}, 32'd1);
    for (int i = 3; i < 8; i++) send_bit(1'(8'hD6 >> i), 1'b0);
    pop_check("R2 partial kept", 8'hD6);
    pulse_reset();
    wait_n(1);
    chk("R3 err sticky", {31'd0, reenable_err}, 32'd1);

    // R2: queued byte survives a disable
    send_byte(8'h9E, 1'b0);
    rx_en = 1'b0;
    wait_n(3);
    pop_check("R2 readable while off", 8'h9E);

    rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(2);
    chk("R3 err cleared by rst_n", {31'd0, reenable_err}, 32'd0);
    configure(1'b1, 1'b1, 1'b0);
    chk("R3 proper sequence", {31'd0, reenable_err}, 32'd0);
    send_byte(8'h81, 1'b0);
    pop_check("R6 falling after restart", 8'h81);

    done = 1'b1;
    finish_run();
  end

endmodule